// File: doc/BRIEF.md
# TDM Slot Engine for a Serial Audio Port

This block adds time-division multiplexed framing to a serial audio port. A frame begins on a frame-sync pulse and is cut into a programmed number of equal slots, each a programmed number of bit clocks wide. Two independent slot masks pick which slots transmit and which slots receive. In a transmit slot the engine takes one word from the transmit stream and shifts it out MSB first. In a receive slot it shifts the serial input into a word and hands that word to the receive stream once the slot ends.

The bit clock reaches the engine as a one-cycle strobe in the system clock domain, and the frame sync is sampled on that strobe. Bit-clock generation, FIFOs and the host register bus sit outside the block. Configuration must be held stable while the port runs. Only the two service enables may change between frames.

Top module: `tdm_slot_engine`

## Requirements
- R1: The slot count is `cfg_slots_i + 1` (1 to 8). Once the last slot of a frame has ended, no data moves and no word is taken or delivered until the next frame sync.
- R2: The slot width is `cfg_size_i + 1` when `cfg_wide_i` is 0 (1 to 16 bits) and `cfg_size_i + 17` when it is 1 (17 to 32 bits). Transmit words are right-justified in `tx_data_i` and leave on `sdo_o` MSB first, one bit per bit strobe.
- R3: A bit strobe with `fsync_i` high starts slot 0, bit 0, even in the middle of a frame. Every later strobe advances one bit, and a new slot begins after each slot-width of strobes.
- R4: With more than one slot, slot s transmits only if `cfg_tx_mask_i[s]` is 1 and receives only if `cfg_rx_mask_i[s]` is 1. With a single slot, both masks are ignored and slot 0 is active in both directions.
- R5: An active transmit slot pulses `tx_ack_o` on its first bit strobe, and takes exactly one word, only while `tx_en_i` and `tx_valid_i` are high. Masked or paused slots take no word. A slot that finds no word sends zeros.
- R6: An active receive slot with `rx_en_i` high raises `rx_valid_o` for one clock, one clock after its last bit strobe. The word carries the first received bit in its MSB and sits right-justified in `rx_data_o`.
- R7: A `start_i` with more than one slot and an all-zero transmit mask is refused. In that case `cfg_err_o` is set and `running_o` stays 0. An accepted start clears `cfg_err_o`.
- R8: With `cfg_tte_i` at 1, `sdo_oe_o` is high only while a word is being shifted out. With `cfg_tte_i` at 0, `sdo_oe_o` is always high. `sdo_o` is 0 whenever no word is being shifted out.
- R9: Clearing `tx_en_i` or `rx_en_i` between frames pauses only that direction. The port keeps running and the other direction keeps its traffic.
- R10: `stop_i` drops `running_o` on the next clock and releases the line. After a new start, nothing moves until a frame sync arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_slots_i | input | 3 | Slots per frame minus one |
| cfg_wide_i | input | 1 | Extended width flag, adds 16 to the width |
| cfg_size_i | input | 4 | Slot width minus one, modulo 16 |
| cfg_tx_mask_i | input | 8 | Transmit active-slot mask, bit s for slot s |
| cfg_rx_mask_i | input | 8 | Receive active-slot mask, bit s for slot s |
| cfg_tte_i | input | 1 | Release the data line when not sending |
| tx_en_i | input | 1 | Transmit service enable |
| rx_en_i | input | 1 | Receive service enable |
| start_i | input | 1 | Start request pulse |
| stop_i | input | 1 | Stop request pulse |
| bit_tick_i | input | 1 | One-clock strobe per bit clock |
| fsync_i | input | 1 | Frame sync, sampled on the bit strobe |
| sdi_i | input | 1 | Serial data in |
| tx_data_i | input | 32 | Transmit word, right-justified |
| tx_valid_i | input | 1 | Transmit word available |
| tx_ack_o | output | 1 | Transmit word taken this clock |
| rx_data_o | output | 32 | Received word, right-justified |
| rx_valid_o | output | 1 | Received word valid pulse |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial data output enable |
| running_o | output | 1 | Port is running |
| cfg_err_o | output | 1 | Last start refused for an empty transmit mask |

## Verification
A slot counter that drifts by even one bit strobe moves the next `tx_ack_o` pulse to the wrong clock. It also reshuffles the `sdo_o` bit pattern within that slot. The reference model checks both on every clock, so such a fault shows up at the first slot boundary after it occurs. A wrong mask decode or width decode shows up as a word taken from the wrong slot or a receive word of the wrong length. That is visible within one frame, and again in the per-scenario counts of words taken and delivered. A fault in the output-enable or run-state logic appears at once on `sdo_oe_o` or `running_o`.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  typedef enum logic {
    RUN_OFF = 1'b0,
    RUN_ON  = 1'b1
  } run_e;
endpackage

// File: rtl/tdm_slot_ctr.sv
module tdm_slot_ctr #(
  parameter int SLOTS  = 8,
  parameter int BIT_W  = 5,
  parameter int CNT_W  = $clog2(SLOTS),
  parameter int SLOT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              fsync_i,
  input  logic [SLOT_W-1:0] nslots_i,
  input  logic [BIT_W:0]    width_i,
  output logic [CNT_W-1:0]  slot_o,
  output logic              step_o,
  output logic              active_o,
  output logic              first_o,
  output logic              last_o
);
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              synced_q, sync_d;
  logic              end_of_slot;

  assign end_of_slot = ({1'b0, bit_q} == width_i - 1'b1);
  assign sync_d      = synced_q | fsync_i;

  always_comb begin
    if (fsync_i) begin
      slot_d = '0;
      bit_d  = '0;
    end else if (end_of_slot) begin
      slot_d = (slot_q == SLOT_W'(SLOTS)) ? slot_q : slot_q + 1'b1;
      bit_d  = '0;
    end else begin
      slot_d = slot_q;
      bit_d  = bit_q + 1'b1;
    end
  end

  assign step_o   = run_i & tick_i;
  assign active_o = step_o & sync_d & (slot_d < nslots_i);
  assign first_o  = (bit_d == '0);
  assign last_o   = ({1'b0, bit_d} == width_i - 1'b1);
  assign slot_o   = slot_d[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      synced_q <= 1'b0;
      slot_q   <= SLOT_W'(SLOTS);
      bit_q    <= '0;
    end else if (!run_i) begin
      synced_q <= 1'b0;
      slot_q   <= SLOT_W'(SLOTS);
      bit_q    <= '0;
    end else if (step_o && sync_d) begin
      synced_q <= 1'b1;
      slot_q   <= slot_d;
      bit_q    <= bit_d;
    end
  end
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane #(
  parameter int DATA_W = 32,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              step_i,
  input  logic              active_i,
  input  logic              first_i,
  input  logic              take_i,
  input  logic [BIT_W:0]    width_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              bit_o,
  output logic              send_o
);
  logic [DATA_W-1:0] sr_q;
  logic              send_q;
  logic [BIT_W:0]    pad;

  assign pad = (BIT_W + 1)'(DATA_W) - width_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      send_q <= 1'b0;
    end else if (!run_i) begin
      sr_q   <= '0;
      send_q <= 1'b0;
    end else if (step_i) begin
      if (!active_i) begin
        send_q <= 1'b0;
      end else if (first_i) begin
        send_q <= take_i;
        if (take_i) sr_q <= word_i << pad;
      end else begin
        sr_q <= sr_q << 1;
      end
    end
  end

  assign bit_o  = sr_q[DATA_W-1];
  assign send_o = send_q;
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              active_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic              cap_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] acc_q, acc_d, data_q;
  logic              valid_q;

  assign acc_d = first_i ? DATA_W'(sdi_i) : {acc_q[DATA_W-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (step_i && active_i && cap_i) begin
        acc_q <= acc_d;
        if (last_i) begin
          data_q  <= acc_d;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/tdm_slot_engine.sv
module tdm_slot_engine
  import tdm_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SIZE_W = 4,
  localparam int CNT_W  = $clog2(SLOTS),
  localparam int SLOT_W = $clog2(SLOTS + 1),
  localparam int DATA_W = 2 * (2 ** SIZE_W),
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cfg_slots_i,
  input  logic              cfg_wide_i,
  input  logic [SIZE_W-1:0] cfg_size_i,
  input  logic [SLOTS-1:0]  cfg_tx_mask_i,
  input  logic [SLOTS-1:0]  cfg_rx_mask_i,
  input  logic              cfg_tte_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              bit_tick_i,
  input  logic              fsync_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ack_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              running_o,
  output logic              cfg_err_o
);
  run_e              run_q;
  logic              err_q;
  logic              running, net_mode;
  logic [SLOT_W-1:0] nslots;
  logic [BIT_W:0]    width;
  logic [CNT_W-1:0]  slot;
  logic              step, active, first, last;
  logic              tx_sel, rx_sel, take, cap;
  logic              tx_bit, tx_send, sending;

  assign running  = (run_q == RUN_ON);
  assign net_mode = (cfg_slots_i != '0);
  assign nslots   = SLOT_W'(cfg_slots_i) + SLOT_W'(1);
  // extended flag sits just above the size field: adds half the max width
  assign width    = {1'b0, cfg_wide_i, cfg_size_i} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= RUN_OFF;
      err_q <= 1'b0;
    end else if (stop_i) begin
      run_q <= RUN_OFF;
    end else if (start_i && !running) begin
      if (net_mode && cfg_tx_mask_i == '0) begin
        err_q <= 1'b1;
      end else begin
        run_q <= RUN_ON;
        err_q <= 1'b0;
      end
    end
  end

  tdm_slot_ctr #(
    .SLOTS (SLOTS),
    .BIT_W (BIT_W),
    .CNT_W (CNT_W),
    .SLOT_W(SLOT_W)
  ) i_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (running),
    .tick_i  (bit_tick_i),
    .fsync_i (fsync_i),
    .nslots_i(nslots),
    .width_i (width),
    .slot_o  (slot),
    .step_o  (step),
    .active_o(active),
    .first_o (first),
    .last_o  (last)
  );

  // single-slot framing ignores the masks
  assign tx_sel = !net_mode || cfg_tx_mask_i[slot];
  assign rx_sel = !net_mode || cfg_rx_mask_i[slot];
  assign take   = active && first && tx_sel && tx_en_i && tx_valid_i;
  assign cap    = rx_sel && rx_en_i;

  tdm_tx_lane #(
    .DATA_W(DATA_W),
    .BIT_W (BIT_W)
  ) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (running),
    .step_i  (step),
    .active_i(active),
    .first_i (first),
    .take_i  (take),
    .width_i (width),
    .word_i  (tx_data_i),
    .bit_o   (tx_bit),
    .send_o  (tx_send)
  );

  tdm_rx_lane #(
    .DATA_W(DATA_W)
  ) i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .active_i(active),
    .first_i (first),
    .last_i  (last),
    .cap_i   (cap),
    .sdi_i   (sdi_i),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o)
  );

  assign sending   = tx_send && running;
  assign tx_ack_o  = take;
  assign sdo_o     = sending && tx_bit;
  assign sdo_oe_o  = cfg_tte_i ? sending : 1'b1;
  assign running_o = running;
  assign cfg_err_o = err_q;
endmodule

// File: rtl/tdm_slot_engine_chk.sv
module tdm_slot_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_tick_i,
  input logic tx_valid_i,
  input logic tx_en_i,
  input logic cfg_tte_i,
  input logic stop_i,
  input logic tx_ack_o,
  input logic rx_valid_o,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic running_o,
  input logic cfg_err_o
);
  a_r5_ack_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ack_o |-> (bit_tick_i && running_o && tx_valid_i && tx_en_i));

  a_r6_rx_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(bit_tick_i));

  a_r6_rx_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(running_o));

  a_r7_err_blocks_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !running_o);

  a_r8_driven_no_tte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_tte_i |-> sdo_oe_o);

  a_r8_released_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);

  a_r10_stop_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !running_o);
endmodule

bind tdm_slot_engine tdm_slot_engine_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_tick_i(bit_tick_i),
  .tx_valid_i(tx_valid_i),
  .tx_en_i   (tx_en_i),
  .cfg_tte_i (cfg_tte_i),
  .stop_i    (stop_i),
  .tx_ack_o  (tx_ack_o),
  .rx_valid_o(rx_valid_o),
  .sdo_o     (sdo_o),
  .sdo_oe_o  (sdo_oe_o),
  .running_o (running_o),
  .cfg_err_o (cfg_err_o)
);

// File: tb/test_tdm_slot_engine.sv
module test_tdm_slot_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  cfg_slots_i = '0;
  logic        cfg_wide_i = 1'b0;
  logic [3:0]  cfg_size_i = '0;
  logic [7:0]  cfg_tx_mask_i = '0;
  logic [7:0]  cfg_rx_mask_i = '0;
  logic        cfg_tte_i = 1'b1;
  logic        tx_en_i = 1'b1;
  logic        rx_en_i = 1'b1;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic        bit_tick_i = 1'b0;
  logic        fsync_i = 1'b0;
  logic        sdi_i = 1'b0;
  logic [31:0] tx_data_i = '0;
  logic        tx_valid_i = 1'b0;
  logic        tx_ack_o;
  logic [31:0] rx_data_o;
  logic        rx_valid_o;
  logic        sdo_o, sdo_oe_o, running_o, cfg_err_o;

  tdm_slot_engine i_tdm_slot_engine (.*);

  always #4 clk_i = ~clk_i;

  int tests = 0;
  int fails = 0;
  int pop_cnt = 0;
  int rx_cnt = 0;
  logic [31:0] src_q[$];
  logic [31:0] ref_q[$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model state
  bit          m_run, m_sync, m_send, m_err, exp_rxv;
  int          m_slot, m_bit, m_idx;
  logic [31:0] m_word, m_acc, exp_rxd;

  always @(posedge clk_i) begin
    int  w, ns;
    bit  net, adv, inn, txact, rxact, take;
    if (!rst_ni) begin
      m_run = 0; m_sync = 0; m_send = 0; m_err = 0; exp_rxv = 0;
      m_slot = 8; m_bit = 0; m_idx = 0; m_word = '0; m_acc = '0; exp_rxd = '0;
    end else begin
      w   = cfg_wide_i ? int'(cfg_size_i) + 17 : int'(cfg_size_i) + 1;
      ns  = int'(cfg_slots_i) + 1;
      net = ns > 1;
      take = 0;
      exp_rxv = 0;
      if (m_run && bit_tick_i) begin
        adv = 0;
        if (fsync_i) begin
          m_sync = 1; m_slot = 0; m_bit = 0; adv = 1;
        end else if (m_sync) begin
          if (m_bit == w - 1) begin
            m_bit = 0;
            if (m_slot < 8) m_slot++;
          end else m_bit++;
          adv = 1;
        end
        inn   = adv && (m_slot < ns);
        txact = inn && (!net || cfg_tx_mask_i[m_slot]);
        rxact = inn && (!net || cfg_rx_mask_i[m_slot]);
        if (!inn) m_send = 0;
        else if (m_bit == 0) begin
          if (txact && tx_en_i && ref_q.size() > 0) begin
            take = 1; m_word = ref_q.pop_front(); m_send = 1; m_idx = w - 1;
          end else m_send = 0;
        end else if (m_send) m_idx--;
        if (rxact && rx_en_i) begin
          m_acc = (m_bit == 0) ? {31'b0, sdi_i} : {m_acc[30:0], sdi_i};
          if (m_bit == w - 1) begin
            exp_rxv = 1; exp_rxd = m_acc;
          end
        end
      end
      // R5: word taken exactly on active first-bit strobes
      chk(tx_ack_o == take, "R5", "tx_ack", tx_ack_o, take);
      if (tx_ack_o) begin
        void'(src_q.pop_front());
        pop_cnt++;
      end
      if (stop_i) begin
        m_run = 0; m_sync = 0; m_send = 0;
      end else if (start_i && !m_run) begin
        if (net && cfg_tx_mask_i == 8'h00) m_err = 1;
        else begin m_run = 1; m_err = 0; m_sync = 0; end
      end
      #2;
      begin
        bit es;
        es = m_send && m_run;
        chk(sdo_o == (es ? m_word[m_idx] : 1'b0), "R2", "sdo", sdo_o, es ? m_word[m_idx] : 1'b0);
        chk(sdo_oe_o == (cfg_tte_i ? es : 1'b1), "R8", "sdo_oe", sdo_oe_o, cfg_tte_i ? es : 1'b1);
        chk(rx_valid_o == exp_rxv, "R6", "rx_valid", rx_valid_o, exp_rxv);
        if (exp_rxv) chk(rx_data_o == exp_rxd, "R6", "rx_data", rx_data_o, exp_rxd);
        if (rx_valid_o) rx_cnt++;
        chk(running_o == m_run, "R7", "running", running_o, m_run);
        chk(cfg_err_o == m_err, "R7", "cfg_err", cfg_err_o, m_err);
      end
    end
  end

  always @(negedge clk_i) begin
    tx_valid_i = src_q.size() > 0;
    tx_data_i  = (src_q.size() > 0) ? src_q[0] : 32'h0;
  end

  task automatic do_tick(input bit fs);
    @(negedge clk_i);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bit_tick_i = 1'b1; fsync_i = fs; sdi_i = lfsr[0];
    @(negedge clk_i);
    #1;
    bit_tick_i = 1'b0; fsync_i = 1'b0;
  endtask

  task automatic frame(input int len);
    for (int t = 0; t < len; t++) do_tick(t == 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic pulse_start();
    @(negedge clk_i); #1; start_i = 1'b1;
    @(negedge clk_i); #1; start_i = 1'b0;
    idle(2);
  endtask

  task automatic pulse_stop();
    @(negedge clk_i); #1; stop_i = 1'b1;
    @(negedge clk_i); #1; stop_i = 1'b0;
    idle(2);
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      src_q.push_back(32'h9E3779B9 * (seed + i) + 32'h1234567);
      ref_q.push_back(32'h9E3779B9 * (seed + i) + 32'h1234567);
    end
  endtask

  task automatic seg_clear();
    pop_cnt = 0; rx_cnt = 0;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    #1 rst_ni = 1'b1;
    idle(2);
    // reset state
    chk(running_o == 1'b0, "R10", "reset running", running_o, 0);
    chk(cfg_err_o == 1'b0, "R7", "reset err", cfg_err_o, 0);
    chk(sdo_oe_o == 1'b0, "R8", "reset oe", sdo_oe_o, 0);
    chk(rx_valid_o == 1'b0, "R6", "reset rx_valid", rx_valid_o, 0);
    fill(40, 1);

    // R7: network mode, empty tx mask -> refused
    cfg_slots_i = 3'd3; cfg_tx_mask_i = 8'h00; cfg_rx_mask_i = 8'h0F;
    pulse_start();
    chk(cfg_err_o == 1'b1, "R7", "refused err", cfg_err_o, 1);
    chk(running_o == 1'b0, "R7", "refused running", running_o, 0);

    // R4: single slot ignores both masks, 16-bit width
    cfg_slots_i = 3'd0; cfg_wide_i = 1'b0; cfg_size_i = 4'd15; cfg_rx_mask_i = 8'h00;
    pulse_start();
    chk(cfg_err_o == 1'b0, "R7", "accepted start clears err", cfg_err_o, 0);
    seg_clear();
    frame(20); frame(20); idle(3);
    chk(pop_cnt == 2, "R4", "single-slot pops", pop_cnt, 2);
    chk(rx_cnt == 2, "R4", "single-slot rx words", rx_cnt, 2);
    pulse_stop();

    // R1 R3 R4: four 8-bit slots, separate masks
    cfg_slots_i = 3'd3; cfg_size_i = 4'd7; cfg_tx_mask_i = 8'h05; cfg_rx_mask_i = 8'h06;
    pulse_start();
    seg_clear();
    frame(35); frame(35); frame(35); idle(3);
    chk(pop_cnt == 6, "R1", "4-slot pops", pop_cnt, 6);
    chk(rx_cnt == 6, "R4", "4-slot rx words", rx_cnt, 6);
    pulse_stop();

    // R2 R8: eight 24-bit slots, line always driven
    cfg_slots_i = 3'd7; cfg_wide_i = 1'b1; cfg_size_i = 4'd7;
    cfg_tx_mask_i = 8'h81; cfg_rx_mask_i = 8'hFF; cfg_tte_i = 1'b0;
    pulse_start();
    seg_clear();
    frame(194); frame(194); idle(3);
    chk(pop_cnt == 4, "R2", "24-bit pops", pop_cnt, 4);
    chk(rx_cnt == 16, "R2", "24-bit rx words", rx_cnt, 16);

    // R9: pause one direction at a time while running
    tx_en_i = 1'b0;
    seg_clear();
    frame(194); idle(3);
    chk(pop_cnt == 0, "R9", "tx paused pops", pop_cnt, 0);
    chk(rx_cnt == 8, "R9", "rx unaffected", rx_cnt, 8);
    chk(running_o == 1'b1, "R9", "still running", running_o, 1);
    tx_en_i = 1'b1; rx_en_i = 1'b0;
    seg_clear();
    frame(194); idle(3);
    chk(pop_cnt == 2, "R9", "tx resumed pops", pop_cnt, 2);
    chk(rx_cnt == 0, "R9", "rx paused words", rx_cnt, 0);
    rx_en_i = 1'b1;
    pulse_stop();

    // R5: 1-bit slots with transmit underflow
    cfg_slots_i = 3'd2; cfg_wide_i = 1'b0; cfg_size_i = 4'd0;
    cfg_tx_mask_i = 8'h07; cfg_rx_mask_i = 8'h05; cfg_tte_i = 1'b1;
    src_q.delete(); ref_q.delete();
    idle(2);
    fill(4, 100);
    pulse_start();
    seg_clear();
    frame(5); frame(5); idle(3);
    chk(pop_cnt == 4, "R5", "underflow pops", pop_cnt, 4);
    chk(rx_cnt == 4, "R6", "1-bit rx words", rx_cnt, 4);
    pulse_stop();

    // R3: 32-bit slots, early frame sync restarts slot 0
    cfg_slots_i = 3'd1; cfg_wide_i = 1'b1; cfg_size_i = 4'd15;
    cfg_tx_mask_i = 8'h02; cfg_rx_mask_i = 8'h03;
    fill(10, 200);
    pulse_start();
    seg_clear();
    frame(40); frame(66); idle(3);
    chk(pop_cnt == 2, "R3", "restart pops", pop_cnt, 2);
    chk(rx_cnt == 3, "R3", "restart rx words", rx_cnt, 3);

    // R10: stop releases, restart waits for frame sync
    pulse_stop();
    chk(running_o == 1'b0, "R10", "stopped", running_o, 0);
    chk(sdo_oe_o == 1'b0, "R10", "released", sdo_oe_o, 0);
    pulse_start();
    seg_clear();
    for (int i = 0; i < 10; i++) do_tick(1'b0);
    idle(3);
    chk(pop_cnt == 0, "R10", "no sync pops", pop_cnt, 0);
    chk(rx_cnt == 0, "R10", "no sync rx", rx_cnt, 0);
    frame(66); idle(3);
    chk(pop_cnt == 1, "R10", "synced pops", pop_cnt, 1);
    chk(rx_cnt == 2, "R1", "synced rx words", rx_cnt, 2);
    pulse_stop();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule